// File: doc/BRIEF.md
# Receive Descriptor Writeback Builder

This block sits beside a receive DMA engine and produces the status half of each receive descriptor. It watches an incoming frame as a stream of byte beats, counts the bytes, and when the frame closes it works out how the frame divides into host buffers of one selectable size. It then emits one 64-bit status quadword per buffer: the byte count for that buffer, the frame checksum, the status byte, the error byte and the VLAN tag field.

Because the whole frame has been counted before anything is emitted, results from side units (checksum value, VLAN tag, checksum flags, error flags) can be sampled on the last beat and still be placed in the first descriptor. A frame that carries receive errors while storing of bad frames is disabled produces no output at all. Each emitted word comes with the index of the ring buffer it describes, and the input stream is held off until the last word of the frame has been taken.

Top module: `rx_wb_builder`

## Requirements
- R1: Each accepted beat with `inSof` high opens a frame and counts as its first byte; each later accepted beat counts one byte until the beat with `inEof` high. Accepted beats with `inSof` low while no frame is open are ignored.
- R2: The buffer size is 256 << `bufSizeSel` bytes for select values 0 to 6 and 16384 bytes for value 7, sampled on the final beat of the frame.
- R3: A frame of N bytes with buffer size B yields ceil(N/B) descriptors; every descriptor but the last has length B and the last has length N - (count-1)*B.
- R4: The descriptor word holds length in bits 15:0, checksum in 31:16, status in 39:32, errors in 47:40 and the VLAN field in 63:48.
- R5: Status bit 0 (done) is 1 in every descriptor; status bit 1 (end of frame) is 1 only in the last descriptor; a descriptor that is not last has all other status bits, the error byte and the VLAN field at zero.
- R6: The checksum field carries `sideCsum` in the first descriptor of a frame and zero in every other descriptor.
- R7: In the last descriptor, status bit 7 is `sideInexact`, bit 6 `sideIpDone`, bit 5 `sideL4Done`, bit 4 is zero, bit 3 `sideVlanHit` and bit 2 `sideIgnoreCsum`.
- R8: The VLAN field of the last descriptor is `sideTci` when `sideVlanHit` is 1, and zero otherwise.
- R9: The error byte of the last descriptor holds `sideErr` bits 0 (CRC/alignment), 1 (symbol), 2 (sequence) and 4 (carrier extension); bit 7 (data error) is `sideErr[7]` or any beat of the frame with `inRxEr` high; bit 3 is zero; bit 6 (IP checksum error) is kept only when `sideIpDone` is 1 and bit 5 (L4 checksum error) only when `sideL4Done` is 1.
- R10: With `storeBad` low, a frame whose error byte has any of bits 0, 1, 2, 4 or 7 set emits no descriptor and leaves `bufIdx` unchanged; checksum error bits 5 and 6 alone never drop a frame.
- R11: While `descValid` is high and `descReady` low, `descWord` and `bufIdx` hold; `inReady` is low whenever a descriptor is pending.
- R12: `bufIdx` names the buffer of the current descriptor, advances by one after each accepted descriptor and wraps modulo 2^`IdxW`.
- R13: After reset `descValid` is 0, `inReady` is 1 and `bufIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A byte beat is offered |
| inReady | output | 1 | Beat accepted on this cycle when high with inValid |
| inSof | input | 1 | Beat is the first byte of a frame |
| inEof | input | 1 | Beat is the last byte of a frame |
| inRxEr | input | 1 | Data error seen on this byte |
| bufSizeSel | input | 3 | Host buffer size select |
| storeBad | input | 1 | Keep frames that carry receive errors |
| sideCsum | input | 16 | Frame checksum from the checksum unit |
| sideTci | input | 16 | VLAN tag control information |
| sideInexact | input | 1 | Frame passed only an inexact address filter |
| sideIpDone | input | 1 | IP checksum was computed |
| sideL4Done | input | 1 | TCP/UDP checksum was computed |
| sideVlanHit | input | 1 | Frame carried a VLAN tag |
| sideIgnoreCsum | input | 1 | Checksum indications should be ignored |
| sideErr | input | 8 | Frame error flags from side units |
| descValid | output | 1 | A descriptor word is offered |
| descReady | input | 1 | Consumer takes the word on this cycle |
| descWord | output | 64 | Descriptor status quadword |
| bufIdx | output | IdxW | Ring index of the buffer described |

## Verification
The bench builds the block with `IdxW` set to 3, so the buffer index wraps after eight descriptors and the wrap is crossed several times in one run. `CntW` stays at 16, which admits frames longer than the largest buffer, so a frame of about 20000 bytes with the 16384-byte setting reaches a two-descriptor split at the top size. The consumer's ready line follows a pseudo-random pattern, bringing held descriptors and back-to-back acceptance within reach.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

  typedef struct packed {
    logic frameStart;
    logic byteAcc;
    logic eofLoad;
    logic descFire;
  } rxdwStrobes_t;

  typedef struct packed {
    logic inexact;
    logic ipDone;
    logic l4Done;
    logic vlanHit;
    logic ignoreCsum;
  } rxdwFlags_t;

  // error bits that make a frame bad: data, carrier ext, sequence, symbol, CRC
  localparam logic [7:0] FRAME_ERR_MASK = 8'b1001_0111;
  localparam logic [2:0] MAX_SIZE_SEL = 3'd6;

  function automatic logic [16:0] bufBytesFor(input logic [2:0] sel);
    if (sel > MAX_SIZE_SEL) return 17'd16384;
    return 17'd256 << sel;
  endfunction

endpackage

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
  import rxdw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inSof,
  input  logic         inEof,
  input  logic         descReady,
  input  logic         dropNow,
  input  logic         descLast,
  output logic         inReady,
  output logic         descValid,
  output rxdwStrobes_t strobes
);

  typedef enum logic {stIdle, stEmit} ctrlState_t;

  ctrlState_t state;
  logic       inFrame;
  logic       accept;
  logic       eofBeat;

  assign inReady   = (state == stIdle);
  assign descValid = (state == stEmit);
  assign accept    = inValid && inReady;

  always_comb begin
    strobes            = '0;
    strobes.frameStart = accept && inSof;
    strobes.byteAcc    = accept && !inSof && inFrame;
    eofBeat            = (strobes.frameStart || strobes.byteAcc) && inEof;
    strobes.eofLoad    = eofBeat && !dropNow;
    strobes.descFire   = descValid && descReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= stIdle;
      inFrame <= 1'b0;
    end else begin
      if (eofBeat)                 inFrame <= 1'b0;
      else if (strobes.frameStart) inFrame <= 1'b1;

      case (state)
        stIdle:  if (strobes.eofLoad) state <= stEmit;
        stEmit:  if (strobes.descFire && descLast) state <= stIdle;
        default: state <= stIdle;
      endcase
    end
  end

  // no byte may be taken while descriptors of a frame are still pending
  assert_no_accept_in_emit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == stEmit) |-> !(strobes.frameStart || strobes.byteAcc));

endmodule

// File: rtl/rxdw_datapath.sv
module rxdw_datapath
  import rxdw_pkg::*;
#(
  parameter int CntW = 16,
  parameter int IdxW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxdwStrobes_t     strobes,
  input  logic             inRxEr,
  input  logic [2:0]       bufSizeSel,
  input  logic             storeBad,
  input  logic [15:0]      sideCsum,
  input  logic [15:0]      sideTci,
  input  rxdwFlags_t       sideFlags,
  input  logic [7:0]       sideErr,
  output logic             dropNow,
  output logic             descLast,
  output logic [63:0]      descWord,
  output logic [IdxW-1:0]  bufIdx
);

  localparam logic [CntW-1:0] CNT_MAX = '1;
  localparam logic [CntW-1:0] CNT_ONE = CntW'(1);

  logic [CntW-1:0] byteCnt;
  logic            rxErSeen;
  logic [CntW-1:0] nextCnt;
  logic            nextRxEr;
  logic [7:0]      errIn;

  logic [CntW-1:0] remLen;
  logic [CntW-1:0] bufBytesQ;
  logic            firstDesc;
  logic [15:0]     csumQ;
  logic [15:0]     tciQ;
  rxdwFlags_t      flagsQ;
  logic [7:0]      errQ;

  logic [CntW-1:0] curLen;
  logic [15:0]     lenField;
  logic [15:0]     csumField;
  logic [7:0]      statusField;
  logic [7:0]      errField;
  logic [15:0]     specialField;

  // ---- frame accounting ----
  always_comb begin
    if (strobes.frameStart) begin
      nextCnt  = CNT_ONE;
      nextRxEr = inRxEr;
    end else begin
      nextCnt  = (byteCnt == CNT_MAX) ? byteCnt : byteCnt + CNT_ONE;
      nextRxEr = rxErSeen || inRxEr;
    end
    errIn   = {sideErr[7] | nextRxEr, sideErr[6:4], 1'b0, sideErr[2:0]};
    dropNow = !storeBad && |(errIn & FRAME_ERR_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      rxErSeen <= 1'b0;
    end else if (strobes.frameStart || strobes.byteAcc) begin
      byteCnt  <= nextCnt;
      rxErSeen <= nextRxEr;
    end
  end

  // ---- per-frame results latched on the final beat ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csumQ     <= '0;
      tciQ      <= '0;
      flagsQ    <= '0;
      errQ      <= '0;
      bufBytesQ <= '0;
    end else if (strobes.eofLoad) begin
      csumQ     <= sideCsum;
      tciQ      <= sideTci;
      flagsQ    <= sideFlags;
      errQ      <= {errIn[7], errIn[6] & sideFlags.ipDone,
                    errIn[5] & sideFlags.l4Done, errIn[4:0]};
      bufBytesQ <= CntW'(bufBytesFor(bufSizeSel));
    end
  end

  // ---- buffer split and ring index ----
  assign descLast = (remLen <= bufBytesQ);
  assign curLen   = descLast ? remLen : bufBytesQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remLen    <= '0;
      firstDesc <= 1'b0;
      bufIdx    <= '0;
    end else if (strobes.eofLoad) begin
      remLen    <= nextCnt;
      firstDesc <= 1'b1;
    end else if (strobes.descFire) begin
      if (!descLast) remLen <= remLen - bufBytesQ;
      firstDesc <= 1'b0;
      bufIdx    <= bufIdx + IdxW'(1);
    end
  end

  // ---- descriptor word assembly ----
  always_comb begin
    lenField  = 16'(curLen);
    csumField = firstDesc ? csumQ : 16'h0000;
    if (descLast) begin
      statusField  = {flagsQ.inexact, flagsQ.ipDone, flagsQ.l4Done, 1'b0,
                      flagsQ.vlanHit, flagsQ.ignoreCsum, 1'b1, 1'b1};
      errField     = errQ;
      specialField = flagsQ.vlanHit ? tciQ : 16'h0000;
    end else begin
      statusField  = 8'h01;
      errField     = 8'h00;
      specialField = 16'h0000;
    end
    descWord = {specialField, errField, statusField, csumField, lenField};
  end

endmodule

// File: rtl/rx_wb_builder.sv
module rx_wb_builder
  import rxdw_pkg::*;
#(
  parameter int CntW = 16,
  parameter int IdxW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic            inSof,
  input  logic            inEof,
  input  logic            inRxEr,
  input  logic [2:0]      bufSizeSel,
  input  logic            storeBad,
  input  logic [15:0]     sideCsum,
  input  logic [15:0]     sideTci,
  input  logic            sideInexact,
  input  logic            sideIpDone,
  input  logic            sideL4Done,
  input  logic            sideVlanHit,
  input  logic            sideIgnoreCsum,
  input  logic [7:0]      sideErr,
  output logic            descValid,
  input  logic            descReady,
  output logic [63:0]     descWord,
  output logic [IdxW-1:0] bufIdx
);

  rxdwStrobes_t strobes;
  rxdwFlags_t   sideFlags;
  logic         dropNow;
  logic         descLast;

  assign sideFlags = '{inexact: sideInexact, ipDone: sideIpDone, l4Done: sideL4Done,
                       vlanHit: sideVlanHit, ignoreCsum: sideIgnoreCsum};

  rxdw_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSof     (inSof),
    .inEof     (inEof),
    .descReady (descReady),
    .dropNow   (dropNow),
    .descLast  (descLast),
    .inReady   (inReady),
    .descValid (descValid),
    .strobes   (strobes)
  );

  rxdw_datapath #(.CntW(CntW), .IdxW(IdxW)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inRxEr     (inRxEr),
    .bufSizeSel (bufSizeSel),
    .storeBad   (storeBad),
    .sideCsum   (sideCsum),
    .sideTci    (sideTci),
    .sideFlags  (sideFlags),
    .sideErr    (sideErr),
    .dropNow    (dropNow),
    .descLast   (descLast),
    .descWord   (descWord),
    .bufIdx     (bufIdx)
  );

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(descWord) && $stable(bufIdx)));

  assert_input_stalled_R11: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> !inReady);

  assert_len_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> (descWord[15:0] != 16'd0 && descWord[15:0] <= 16'd16384));

  assert_mid_fields_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descWord[33]) |-> (descWord[63:40] == 24'd0 && descWord[39:34] == 6'd0));

  assert_idx_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady) |=> (bufIdx == $past(bufIdx) + IdxW'(1)));

endmodule

// File: tb/rx_wb_builder_test.sv
`timescale 1ns/1ps
module rx_wb_builder_test;
  localparam int IdxW = 3;
  localparam int CntW = 16;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inReady, inSof, inEof, inRxEr;
  logic [2:0] bufSizeSel;
  logic storeBad;
  logic [15:0] sideCsum, sideTci;
  logic sideInexact, sideIpDone, sideL4Done, sideVlanHit, sideIgnoreCsum;
  logic [7:0] sideErr;
  logic descValid, descReady;
  logic [63:0] descWord;
  logic [IdxW-1:0] bufIdx;

  always #2 clk = ~clk;

  rx_wb_builder #(.CntW(CntW), .IdxW(IdxW)) uut (.*);

  typedef struct packed {
    logic [63:0]     w;
    logic [IdxW-1:0] idx;
  } expItem_t;

  expItem_t expQ[$];
  logic [IdxW-1:0] expIdx = '0;
  int checks = 0;
  int fails = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // driver: pushes the expected descriptors, then plays the beats
  task automatic sendFrame(input int n, input logic [2:0] sel, input bit sb,
                           input logic [15:0] csum, input logic [15:0] tci,
                           input bit pif, input bit ipd, input bit l4d,
                           input bit vlan, input bit ign,
                           input logic [7:0] serr, input int rxErAt);
    int bytes;
    int cnt;
    logic [7:0] e;
    bit drop;
    bytes = (sel > 3'd6) ? 16384 : (256 << sel);
    cnt   = (n + bytes - 1) / bytes;
    e     = serr;
    if (rxErAt >= 0 && rxErAt < n) e[7] = 1'b1;
    e[3]  = 1'b0;
    drop  = !sb && ((e & 8'h97) != 8'h00);        // R10
    e[6]  = e[6] & ipd;
    e[5]  = e[5] & l4d;
    if (!drop) begin
      for (int i = 0; i < cnt; i++) begin
        expItem_t it;
        bit last;
        last = (i == cnt - 1);
        it.w[15:0]  = 16'(last ? n - (cnt - 1) * bytes : bytes);
        it.w[31:16] = (i == 0) ? csum : 16'h0;
        it.w[39:32] = last ? {pif, ipd, l4d, 1'b0, vlan, ign, 1'b1, 1'b1} : 8'h01;
        it.w[47:40] = last ? e : 8'h00;
        it.w[63:48] = (last && vlan) ? tci : 16'h0;
        it.idx      = expIdx;
        expIdx      = expIdx + IdxW'(1);
        expQ.push_back(it);
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        bufSizeSel = sel; storeBad = sb; sideCsum = csum; sideTci = tci;
        sideInexact = pif; sideIpDone = ipd; sideL4Done = l4d;
        sideVlanHit = vlan; sideIgnoreCsum = ign; sideErr = serr;
      end
      inValid = 1'b1;
      inSof   = (i == 0);
      inEof   = (i == n - 1);
      inRxEr  = (i == rxErAt);
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inRxEr = 1'b0;
  endtask

  // R1: beats without a start flag while no frame is open must be ignored
  task automatic strayBeats(input int m);
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = 1'b0; inEof = (i == m - 1); inRxEr = 1'b1;
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0; inRxEr = 1'b0;
  endtask

  // monitor: random ready, stall hold check, scoreboard compare
  initial begin
    logic [7:0] lfsr;
    logic [63:0] heldWord;
    logic [IdxW-1:0] heldIdx;
    bit stalled;
    lfsr = 8'hA5;
    stalled = 1'b0;
    heldWord = '0;
    heldIdx = '0;
    descReady = 1'b0;
    wait (rstN === 1'b1);
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      descReady = lfsr[0] | lfsr[2];
      #1;
      if (descValid) begin
        chk("R11 inReady low while descriptor pending", 64'(inReady), 64'd0);
        if (stalled) begin
          chk("R11 descWord held during stall", descWord, heldWord);
          chk("R11 bufIdx held during stall", 64'(bufIdx), 64'(heldIdx));
        end
      end else if (stalled) begin
        chk("R11 descValid held during stall", 64'(descValid), 64'd1);
      end
      stalled  = descValid && !descReady;
      heldWord = descWord;
      heldIdx  = bufIdx;
      if (descValid && descReady) begin
        if (expQ.size() == 0) begin
          chk("R10 unexpected descriptor", descWord, 64'h0);
          checks--;
          if (descWord == 64'h0) begin fails++; $display("FAIL R10: actual valid descriptor expected none"); end
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk("R4 full descriptor word", descWord, it.w);
          chk("R3 length (R2 size select)", 64'(descWord[15:0]), 64'(it.w[15:0]));
          chk("R6 checksum field", 64'(descWord[31:16]), 64'(it.w[31:16]));
          chk("R5 done/end status bits", 64'(descWord[33:32]), 64'(it.w[33:32]));
          chk("R7 frame status bits", 64'(descWord[39:34]), 64'(it.w[39:34]));
          chk("R9 error byte", 64'(descWord[47:40]), 64'(it.w[47:40]));
          chk("R8 VLAN field", 64'(descWord[63:48]), 64'(it.w[63:48]));
          chk("R12 buffer index", 64'(bufIdx), 64'(it.idx));
        end
      end
    end
  end

  initial begin
    #(4 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual run still going expected finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inRxEr = 1'b0;
    bufSizeSel = 3'd0; storeBad = 1'b0; sideCsum = '0; sideTci = '0;
    sideInexact = 1'b0; sideIpDone = 1'b0; sideL4Done = 1'b0;
    sideVlanHit = 1'b0; sideIgnoreCsum = 1'b0; sideErr = '0;
    repeat (3) @(negedge clk);
    chk("R13 descValid in reset", 64'(descValid), 64'd0);
    chk("R13 inReady in reset", 64'(inReady), 64'd1);
    chk("R13 bufIdx in reset", 64'(bufIdx), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 descValid after reset", 64'(descValid), 64'd0);
    chk("R13 inReady after reset", 64'(inReady), 64'd1);

    // single buffer, VLAN tagged, all flags
    sendFrame(64, 3'd0, 1'b0, 16'hBEEF, 16'h6123, 1, 1, 1, 1, 0, 8'h00, -1);
    // three buffers of 256 with a remainder
    sendFrame(600, 3'd0, 1'b0, 16'h1234, 16'hAAAA, 0, 1, 0, 0, 1, 8'h00, -1);
    // exact multiple of the buffer size
    sendFrame(512, 3'd0, 1'b0, 16'h0F0F, 16'h0000, 1, 0, 0, 0, 0, 8'h00, -1);
    // R1: stray beats, then a short frame
    strayBeats(5);
    sendFrame(10, 3'd1, 1'b0, 16'h5555, 16'h0001, 0, 0, 1, 1, 0, 8'h00, -1);
    // 2048-byte buffers
    sendFrame(5000, 3'd3, 1'b0, 16'hC0DE, 16'h0BAD, 0, 1, 1, 1, 0, 8'h00, -1);
    // select 7 maps to 16384
    sendFrame(20000, 3'd7, 1'b0, 16'h7777, 16'h8008, 1, 0, 1, 0, 0, 8'h00, -1);
    // select 6 exactly one full buffer
    sendFrame(16384, 3'd6, 1'b0, 16'h4242, 16'h0000, 0, 0, 0, 0, 1, 8'h00, -1);
    // R9: bad frame kept, CRC + symbol + mid-frame data error, checksum errors masked/kept
    sendFrame(700, 3'd1, 1'b1, 16'h9999, 16'h0123, 0, 1, 0, 1, 0, 8'h63, 300);
    // R10: same kind of frame dropped when bad frames are not stored
    sendFrame(700, 3'd0, 1'b0, 16'h1111, 16'h2222, 1, 1, 1, 1, 1, 8'h01, -1);
    sendFrame(40, 3'd0, 1'b0, 16'h3333, 16'h0000, 0, 0, 0, 0, 0, 8'h00, 20);
    // R10: checksum errors alone do not drop
    sendFrame(300, 3'd0, 1'b0, 16'hABCD, 16'h0000, 0, 1, 1, 0, 0, 8'h60, -1);
    // carrier extension and sequence errors kept
    sendFrame(1500, 3'd2, 1'b1, 16'hFACE, 16'h0FFF, 0, 0, 0, 1, 0, 8'h14, -1);
    // more short frames to cross the index wrap again
    for (int k = 0; k < 6; k++)
      sendFrame(100 + k * 37, 3'd0, 1'b0, 16'(k * 16'h0101), 16'h0000, 0, 0, 0, 0, 0, 8'h00, -1);

    for (int t = 0; t < 2000 && expQ.size() > 0; t++) @(negedge clk);
    chk("R3 all expected descriptors delivered", 64'(expQ.size()), 64'd0);
    repeat (20) @(negedge clk);
    chk("R10 no trailing descriptor", 64'(descValid), 64'd0);
    chk("R12 final index", 64'(bufIdx), 64'(expIdx));
    finishRun();
  end

endmodule